// File: doc/BRIEF.md
# Reference-Match Interval Timer

This block is a 16-bit up-counting timer. Software sets it up through a small synchronous register bus with byte addresses. A prescaler divides the system clock into counting ticks. The divisor is set by the upper byte of the mode register and by a clock-source field. On every tick the counter is compared with a reference value. A match raises a sticky reference event. In restart mode, a match also returns the counter to zero, so the timer produces periodic events. Software clears an event flag by writing 1 to it. A single level interrupt output follows the reference event whenever the interrupt enable bit is set.

Typical use: write the reference value, write the counter to a known start value, then write the mode register with the enable bit set. The interval is (reference + 1) ticks. Each tick lasts (mode[15:8] + 1) clocks, or 16 times that when the divide-by-16 source is selected. A read request returns its data one cycle later, marked by a valid strobe.

Top module: `gp_ref_timer`

## Requirements
- R1: After reset the mode, reference, capture, counter and event registers all read 0, and `irq` is low.
- R2: Register offsets are mode 0x00, reference 0x04, capture 0x08, counter 0x0C and event 0x11 (event flags in data bits 1:0, with bit 1 the reference event and bit 0 the capture event). Mode, reference and capture read back what was last written. Any other offset reads 0.
- R3: When mode bit 0 is 0 the counter holds its value. A mode write that changes bit 0 from 1 to 0 leaves both the mode register and the reference register at 0.
- R4: Mode bits 2:1 select the tick source. Value 1 gives one tick every mode[15:8]+1 clocks. Value 2 gives one tick every 16*(mode[15:8]+1) clocks. Values 0 and 3 give no ticks.
- R5: On a tick where the counter equals the reference, event bit 1 is set. When mode bit 3 (restart) is 1, the counter becomes 0 on that tick.
- R6: With restart off, the counter keeps incrementing past the reference on every tick and wraps modulo 2^16.
- R7: A write to the event offset clears each flag whose data bit is 1 and leaves the others unchanged. A reference match in the same cycle wins over the clear.
- R8: `irq` is high exactly when mode bit 4 (reference interrupt enable) and event bit 1 are both 1.
- R9: A counter write loads the counter with the written value. The load takes priority over a tick in the same cycle.
- R10: Any write to the mode or reference register restarts the prescaler from zero and suppresses the tick in that cycle.
- R11: A read request returns its data on `rd_data` with `rd_valid` high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus request valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid when rd_valid is high |
| rd_valid | output | 1 | Read data strobe, one cycle after a read request |
| irq | output | 1 | Level interrupt from the reference event |

## Verification
The assertions assume at most one bus request per cycle, with address and data stable across the sampling edge and no unknown values while `bus_sel` is high. The bench meets this by changing bus inputs only on the falling clock edge and by dropping `bus_sel` in idle cycles. The period checks also assume that software does not rewrite the counter while the timer runs, except where a load is the point of the test. The stimulus loads the counter only while the timer is stopped or idle, or right after a mode write, and checks the counts at cycles worked out from the prescaler restart.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int PRE_W  = 12;

  localparam logic [ADDR_W-1:0] OFS_MODE = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_REF  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CAP  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_EVT  = 5'h11;

  localparam int MB_RUN     = 0;
  localparam int MB_RESTART = 3;
  localparam int MB_IRQEN   = 4;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_DIV  = 2'd2,
    SRC_OFF2 = 2'd3
  } src_e;

  // clocks per tick for a prescale byte and source selection
  function automatic logic [PRE_W-1:0] tick_period(input logic [7:0] pre, input src_e src);
    logic [PRE_W-1:0] base;
    base = PRE_W'(pre) + PRE_W'(1);
    return (src == SRC_DIV) ? (base << 4) : base;
  endfunction

  function automatic logic src_runs(input src_e src);
    return (src == SRC_SYS) || (src == SRC_DIV);
  endfunction
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler
  import gpt_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [PW-1:0] period,
  input  logic          restart_pre,
  output logic          tick
);
  logic [PW-1:0] pre_q;
  logic          at_end;

  assign at_end = (pre_q == period - PW'(1));
  assign tick   = active && !restart_pre && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)                      pre_q <= '0;
    else if (restart_pre || !active) pre_q <= '0;
    else if (at_end)                 pre_q <= '0;
    else                             pre_q <= pre_q + PW'(1);
  end

  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period > PW'(1)) |=> !tick);
  assert_cfg_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pre |=> (pre_q == '0));
  assert_idle_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !tick);
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          restart,
  input  logic [DW-1:0] ref_val,
  output logic [DW-1:0] count,
  output logic          match_ev
);
  logic [DW-1:0] cnt_q;

  assign count    = cnt_q;
  assign match_ev = tick && !load && (cnt_q == ref_val);

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (tick) begin
      if (match_ev && restart)     cnt_q <= '0;
      else                         cnt_q <= cnt_q + DW'(1);
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && restart) |=> (cnt_q == '0));
  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !restart) |=> (cnt_q == $past(cnt_q) + DW'(1)));
endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] count,
  input  logic          match_ev,
  output logic [DW-1:0] mode,
  output logic [DW-1:0] ref_val,
  output logic [1:0]    evt,
  output logic          cfg_wr,
  output logic          cnt_load,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          irq
);
  logic [DW-1:0] mode_q, ref_q, cap_q, rdata_q;
  logic [1:0]    evt_q;
  logic          rvalid_q;
  logic          wr_mode, wr_ref, wr_cap, wr_evt, rd_req, stop_req;
  logic [DW-1:0] rd_mux;

  assign wr_mode  = sel && we && (addr == OFS_MODE);
  assign wr_ref   = sel && we && (addr == OFS_REF);
  assign wr_cap   = sel && we && (addr == OFS_CAP);
  assign wr_evt   = sel && we && (addr == OFS_EVT);
  assign cnt_load = sel && we && (addr == OFS_CNT);
  assign rd_req   = sel && !we;
  assign stop_req = wr_mode && mode_q[MB_RUN] && !wdata[MB_RUN];
  assign cfg_wr   = wr_mode || wr_ref;

  always_comb begin
    case (addr)
      OFS_MODE: rd_mux = mode_q;
      OFS_REF:  rd_mux = ref_q;
      OFS_CAP:  rd_mux = cap_q;
      OFS_CNT:  rd_mux = count;
      OFS_EVT:  rd_mux = {{(DW-2){1'b0}}, evt_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      ref_q    <= '0;
      cap_q    <= '0;
      evt_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rd_mux;
      if (stop_req) begin
        mode_q <= '0;
        ref_q  <= '0;
      end else begin
        if (wr_mode) mode_q <= wdata;
        if (wr_ref)  ref_q  <= wdata;
      end
      if (wr_cap) cap_q <= wdata;
      if (wr_evt) evt_q <= evt_q & ~wdata[1:0];
      if (match_ev) evt_q[1] <= 1'b1;
    end
  end

  assign mode     = mode_q;
  assign ref_val  = ref_q;
  assign evt      = evt_q;
  assign rd_data  = rdata_q;
  assign rd_valid = rvalid_q;
  assign irq      = mode_q[MB_IRQEN] & evt_q[1];

  assert_read_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  assert_stop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (mode_q == '0 && ref_q == '0));
  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && wdata[1] && !match_ev) |=> !evt_q[1]);
  assert_match_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> evt_q[1]);
  assert_evt_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_evt && evt_q[1]) |=> evt_q[1]);
endmodule

// File: rtl/gp_ref_timer.sv
module gp_ref_timer
  import gpt_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          irq
);
  logic [DW-1:0] mode, ref_val, count;
  logic [1:0]    evt;
  logic          cfg_wr, cnt_load, tick, match_ev, active;
  logic [PW-1:0] period;
  src_e          src;

  assign src    = src_e'(mode[2:1]);
  assign active = mode[MB_RUN] && src_runs(src);
  assign period = tick_period(mode[15:8], src);

  gpt_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .count(count), .match_ev(match_ev), .mode(mode),
    .ref_val(ref_val), .evt(evt), .cfg_wr(cfg_wr), .cnt_load(cnt_load),
    .rd_data(rd_data), .rd_valid(rd_valid), .irq(irq)
  );

  gpt_prescaler #(.PW(PW)) u_pre (
    .clk(clk), .rst_n(rst_n), .active(active), .period(period),
    .restart_pre(cfg_wr), .tick(tick)
  );

  gpt_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load), .load_val(bus_wdata),
    .restart(mode[MB_RESTART]), .ref_val(ref_val), .count(count), .match_ev(match_ev)
  );

  assert_irq_needs_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt[1] && mode[MB_IRQEN]));
  assert_irq_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[1] && mode[MB_IRQEN]) |-> irq);
  assert_stopped_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[MB_RUN] |-> !tick);
endmodule

// File: tb/sim_gp_ref_timer.sv
`timescale 1ns/1ps
module sim_gp_ref_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] rd_data;
  logic        rd_valid, irq;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct { logic [15:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  gp_ref_timer u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .irq(irq));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R11 unexpected rd_valid actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, rd_data, e.exp);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", {15'b0, irq}, 16'h0);
    rd(5'h00, 16'h0, "R1 mode");
    rd(5'h04, 16'h0, "R1 ref");
    rd(5'h08, 16'h0, "R1 cap");
    rd(5'h0C, 16'h0, "R1 cnt");
    rd(5'h11, 16'h0, "R1 evt");
    // R2 map and unmapped offsets
    wr(5'h08, 16'hBEEF);
    rd(5'h08, 16'hBEEF, "R2 capture");
    rd(5'h14, 16'h0, "R2 unmapped");
    rd(5'h10, 16'h0, "R2 unmapped 0x10");
    // R9 load, R3 hold while stopped
    wr(5'h04, 16'd5);
    wr(5'h0C, 16'd3);
    idle(5);
    rd(5'h0C, 16'd3, "R9 load / R3 hold");
    rd(5'h04, 16'd5, "R2 ref");
    wr(5'h0C, 16'd0);
    // R5 restart mode, R4 source 1 divisor 1
    wr(5'h00, 16'h001B);
    idle(3);
    rd(5'h0C, 16'd3, "R4 sys tick count");
    rd(5'h11, 16'd0, "R5 no event yet");
    idle(1);
    rd(5'h11, 16'd2, "R5 ref event");
    idle(1);
    check("R8 irq on", {15'b0, irq}, 16'h1);
    rd(5'h00, 16'h001B, "R2 mode");
    // freeze (source 0), R7 write-one-to-clear
    wr(5'h00, 16'h0019);
    wr(5'h11, 16'h0001);
    rd(5'h11, 16'd2, "R7 other bit kept");
    idle(1);
    check("R8 irq kept", {15'b0, irq}, 16'h1);
    wr(5'h11, 16'h0002);
    idle(1);
    check("R8 irq off after clear", {15'b0, irq}, 16'h0);
    rd(5'h11, 16'd0, "R7 cleared");
    // R4 prescale byte 2 -> 3 clocks per tick, R10
    wr(5'h04, 16'd100);
    wr(5'h0C, 16'd0);
    wr(5'h00, 16'h020B);
    idle(9);
    rd(5'h0C, 16'd3, "R4 prescale 3");
    // R4 divide-by-16 source, R10 prescaler restart on mode write
    wr(5'h00, 16'h000D);
    wr(5'h0C, 16'd0);
    idle(31);
    rd(5'h0C, 16'd2, "R4 div16");
    // R3 disable clears mode and reference
    wr(5'h00, 16'h0000);
    rd(5'h00, 16'h0, "R3 mode cleared");
    rd(5'h04, 16'h0, "R3 ref cleared");
    idle(20);
    rd(5'h0C, 16'd2, "R3 counter held");
    // R4 source 3 idle
    wr(5'h00, 16'h0007);
    idle(10);
    rd(5'h0C, 16'd2, "R4 source3 idle");
    rd(5'h00, 16'h0007, "R2 mode src3");
    // R6 no restart, R8 enable gating
    wr(5'h04, 16'd4);
    wr(5'h0C, 16'd0);
    wr(5'h00, 16'h0003);
    idle(7);
    rd(5'h0C, 16'd7, "R6 counts past ref");
    rd(5'h11, 16'd2, "R5 event no restart");
    idle(1);
    check("R8 irq masked", {15'b0, irq}, 16'h0);
    wr(5'h00, 16'h0013);
    idle(1);
    check("R8 irq enabled", {15'b0, irq}, 16'h1);
    idle(3);
    if (sb_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R11 missing reads actual=%0d expected=0", sb_q.size());
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule